// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt sources and steers each of them to the interrupt inputs of four processor cores. Every core has four parent interrupt lines, so the block drives sixteen outputs in all. Each source has its own routing byte. The low nibble of that byte picks the cores and the high nibble picks the parent lines. A source raises output `irq_out[c*4+k]` when it is enabled, it is pending, and its routing byte has both core bit c and line bit 4+k set.

Each source has its own trigger condition, built from a polarity bit and an edge-select bit. In level mode the pending state follows the input after the polarity is applied. In edge mode a detected transition sets a sticky bit, and software clears that bit by writing a one to it. Software reaches every register over a simple synchronous word-wide register bus with byte enables. Enables are changed only through separate set and clear registers, so a write never needs a read first. A masked pending register and four per-core pending views let an interrupt handler find the sources that raised its line.

Top module: `lirq_router`

## Requirements
- R1: After reset, every source is disabled, level-sensitive and of polarity 0, every routing byte is 0x00, every readable register returns 0, and `irq_out` is all zero.
- R2: The routing byte of source n sits at byte address n (word n/4, byte lane n%4). Its bits [3:0] are a core bitmap with bit c meaning core c, and its bits [7:4] are a line bitmap with bit 4+k meaning parent line k. The byte reads back as written.
- R3: Writing address 0x28 sets the enable of every source whose data bit is 1. Writing address 0x2C clears the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable in both cases. Address 0x24 reads the enable vector, while 0x28 and 0x2C read 0.
- R4: Address 0x30 holds the polarity bits and address 0x34 holds the edge-select bits, both read/write. For each source, {edge, polarity} = 00 selects level-high, 01 level-low, 10 rising edge and 11 falling edge. The raw input is XORed with the polarity bit before detection.
- R5: In level mode the raw pending bit of a source equals its conditioned input. Writing a one to that bit at 0x40 has no effect on it.
- R6: In edge mode, a 0-to-1 transition of the conditioned input sets a sticky pending bit, and writing a one to that bit at 0x40 clears it. A transition detected in the same cycle as the clear sets the bit. The sticky bit is cleared while the source is in level mode.
- R7: Address 0x40 reads the raw pending bits ANDed with the enables. An edge captured while its source is disabled appears on reads and outputs once the source is enabled.
- R8: `irq_out[c*4+k]` is high when any enabled pending source has core bit c and line bit 4+k set in its routing byte. A routing byte with several bits set drives every output it selects.
- R9: Address 0x50+4c (c = 0 to 3) reads the masked pending sources whose core bit c is set.
- R10: Only byte lanes whose `bus_be` bit is 1 are written. For the set, clear and pending-clear registers, disabled lanes count as zero. Address bits [1:0] are ignored.
- R11: In level mode, an input sampled at clock edge N changes `irq_out` after edge N+1. In edge mode the change comes after edge N+2. A bus write at edge N affects `irq_out` after edge N+1. Read data appears after the edge that samples `bus_rd`, reflects the state before that edge, and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 32 | Raw interrupt sources, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 16 | Parent lines, index core*4+line |

## Verification
A wrong enable, polarity, edge-select or routing bit shows up on `irq_out` within two clock edges of the next active source that uses it. The same fault also appears in the next read of 0x40 or of the per-core views. A sticky bit that is lost or stuck shows as an output that falls too early or never falls after the clear write. The bench compares all sixteen outputs against its model on every cycle, so the fault is caught in the cycle it first appears. A routing fault shows as a line raised at the wrong core or on the wrong parent line in the same cycle the intended output rises.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned SRC_N    = 32;
  localparam int unsigned CORE_N   = 4;
  localparam int unsigned LINE_N   = 4;
  localparam int unsigned ROUTE_W  = CORE_N + LINE_N;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned OUT_N    = CORE_N * LINE_N;
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned ROUTE_WORDS = SRC_N / LANES;
  localparam int unsigned RW_BITS  = $clog2(ROUTE_WORDS);
  localparam int unsigned CV_BITS  = $clog2(CORE_N);

  // word addresses (byte address >> 2)
  localparam logic [WORD_W-1:0] W_ENSTAT = 6'h09;
  localparam logic [WORD_W-1:0] W_ENSET  = 6'h0A;
  localparam logic [WORD_W-1:0] W_ENCLR  = 6'h0B;
  localparam logic [WORD_W-1:0] W_POL    = 6'h0C;
  localparam logic [WORD_W-1:0] W_EDGE   = 6'h0D;
  localparam logic [WORD_W-1:0] W_PEND   = 6'h10;
  localparam logic [WORD_W-1:0] W_VIEW0  = 6'h14;

  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [LANES-1:0]              be,
  output logic [SRC_N-1:0][ROUTE_W-1:0] route_o,
  output logic [SRC_N-1:0]              en_o,
  output logic [SRC_N-1:0]              pol_o,
  output logic [SRC_N-1:0]              edge_o,
  output logic [SRC_N-1:0]              clr_o
);
  logic [WORD_W-1:0]             word;
  logic [DATA_W-1:0]             lane_mask;
  logic [DATA_W-1:0]             wd_m;
  logic [SRC_N-1:0][ROUTE_W-1:0] route_q, route_n;
  logic [SRC_N-1:0]              en_q, en_n, pol_q, pol_n, edge_q, edge_n;
  logic                          route_we, en_we, pol_we, edge_we;

  assign word = addr[ADDR_W-1:2];

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign lane_mask[8*b +: 8] = {8{be[b]}};
    end
  endgenerate

  assign wd_m     = wdata & lane_mask;
  assign route_we = wr && ((word >> RW_BITS) == '0);
  assign en_we    = wr && ((word == W_ENSET) || (word == W_ENCLR));
  assign pol_we   = wr && (word == W_POL);
  assign edge_we  = wr && (word == W_EDGE);
  assign clr_o    = (wr && (word == W_PEND)) ? wd_m : '0;

  always_comb begin
    route_n = route_q;
    for (int b = 0; b < LANES; b++) begin
      if (be[b])
        route_n[int'(word[RW_BITS-1:0]) * LANES + b] = wdata[8*b +: 8];
    end
  end

  always_comb begin
    if (word == W_ENSET) en_n = en_q | wd_m;
    else                 en_n = en_q & ~wd_m;
  end

  assign pol_n  = (pol_q  & ~lane_mask) | (wdata & lane_mask);
  assign edge_n = (edge_q & ~lane_mask) | (wdata & lane_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
    end else begin
      if (route_we) route_q <= route_n;
      if (en_we)    en_q    <= en_n;
      if (pol_we)   pol_q   <= pol_n;
      if (edge_we)  edge_q  <= edge_n;
    end
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign edge_o  = edge_q;

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_ENSET) |=> ((en_q & $past(wd_m)) == $past(wd_m)));
  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_ENCLR) |=> ((en_q & $past(wd_m)) == '0));
  assert_en_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (word == W_ENSET || word == W_ENCLR)) |=>
      ((en_q & ~$past(wd_m)) == ($past(en_q) & ~$past(wd_m))));
endmodule

// File: rtl/lirq_detect.sv
module lirq_detect
  import lirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SRC_N-1:0] pol_i,
  input  logic [SRC_N-1:0] edge_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] pend_o
);
  logic [SRC_N-1:0] cond_q, prev_q, latch_q, latch_n, rise;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      assign rise[i] = cond_q[i] & ~prev_q[i];

      always_comb begin
        if (!edge_i[i])     latch_n[i] = 1'b0;
        else if (rise[i])   latch_n[i] = 1'b1;
        else if (clr_i[i])  latch_n[i] = 1'b0;
        else                latch_n[i] = latch_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cond_q[i]  <= 1'b0;
          prev_q[i]  <= 1'b0;
          latch_q[i] <= 1'b0;
        end else begin
          cond_q[i]  <= src_i[i] ^ pol_i[i];
          prev_q[i]  <= cond_q[i];
          latch_q[i] <= latch_n[i];
        end
      end

      assign pend_o[i] = edge_i[i] ? latch_q[i] : cond_q[i];
    end
  endgenerate

  assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_i & rise)) |=>
      ((latch_q & $past(edge_i & rise)) == $past(edge_i & rise)));
  assert_level_nolatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~edge_i)) |=> ((latch_q & ~$past(edge_i)) == '0));
endmodule

// File: rtl/lirq_fanout.sv
module lirq_fanout
  import lirq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0][ROUTE_W-1:0] route_i,
  input  logic [SRC_N-1:0]              pend_i,
  output logic [CORE_N-1:0][SRC_N-1:0]  view_o,
  output logic [OUT_N-1:0]              irq_o
);
  logic [LINE_N-1:0][SRC_N-1:0] line_sel;
  logic [OUT_N-1:0]             irq_n, irq_q;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      for (genvar c = 0; c < CORE_N; c++) begin : g_core
        assign view_o[c][i] = pend_i[i] & route_i[i][c];
      end
      for (genvar k = 0; k < LINE_N; k++) begin : g_line
        assign line_sel[k][i] = route_i[i][CORE_N + k];
      end
    end
    for (genvar c = 0; c < CORE_N; c++) begin : g_out_c
      for (genvar k = 0; k < LINE_N; k++) begin : g_out_k
        assign irq_n[c*LINE_N + k] = |(view_o[c] & line_sel[k]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_n;
  end

  assign irq_o = irq_q;

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(|pend_i));
  assert_irq_onecore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_i) == 0) |=> (irq_q == '0));
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [OUT_N-1:0]  irq_out
);
  logic [RST_STAGES-1:0]         rst_sync;
  logic                          rst_int_n;
  logic [SRC_N-1:0][ROUTE_W-1:0] route;
  logic [SRC_N-1:0]              en, pol, edge_sel, clr, pend_raw, pend_m;
  logic [CORE_N-1:0][SRC_N-1:0]  view;
  logic [WORD_W-1:0]             word;
  logic [DATA_W-1:0]             rdata_n, rdata_q;
  logic [WORD_W-1:0]             view_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[RST_STAGES-1];

  lirq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .route_o (route),
    .en_o    (en),
    .pol_o   (pol),
    .edge_o  (edge_sel),
    .clr_o   (clr)
  );

  lirq_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_i  (src_in),
    .pol_i  (pol),
    .edge_i (edge_sel),
    .clr_i  (clr),
    .pend_o (pend_raw)
  );

  assign pend_m = pend_raw & en;

  lirq_fanout u_fanout (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .route_i (route),
    .pend_i  (pend_m),
    .view_o  (view),
    .irq_o   (irq_out)
  );

  assign word     = bus_addr[ADDR_W-1:2];
  assign view_off = word - W_VIEW0;

  always_comb begin
    rdata_n = '0;
    if ((word >> RW_BITS) == '0) begin
      for (int b = 0; b < LANES; b++)
        rdata_n[8*b +: 8] = route[int'(word[RW_BITS-1:0]) * LANES + b];
    end else if (word == W_ENSTAT) begin
      rdata_n = en;
    end else if (word == W_POL) begin
      rdata_n = pol;
    end else if (word == W_EDGE) begin
      rdata_n = edge_sel;
    end else if (word == W_PEND) begin
      rdata_n = pend_m;
    end else if ((view_off >> CV_BITS) == '0) begin
      rdata_n = view[view_off[CV_BITS-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |=> $stable(bus_rdata));
  assert_pend_masked_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && word == W_PEND) |=> ((bus_rdata & ~$past(en)) == '0));
endmodule

// File: tb/lirq_router_bench.sv
`timescale 1ns/1ps
module lirq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_in;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  string cur_tag = "";

  always #2 clk = ~clk;

  lirq_router u_lirq_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [7:0]  m_route [32];
  logic [31:0] m_en, m_pol, m_edge, m_cond, m_prev, m_stick;
  logic [15:0] m_irq;
  logic [31:0] m_rexp;
  logic [31:0] m_rhold;
  bit          rd_due;

  function automatic logic [31:0] m_pend();
    return ((m_edge & m_stick) | (~m_edge & m_cond)) & m_en;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] p, v;
    int w;
    p = m_pend();
    w = a >> 2;
    v = 32'h0;
    if (w < 8) v = {m_route[4*w+3], m_route[4*w+2], m_route[4*w+1], m_route[4*w]};
    else if (w == 9)  v = m_en;
    else if (w == 12) v = m_pol;
    else if (w == 13) v = m_edge;
    else if (w == 16) v = p;
    else if (w >= 20 && w < 24) begin
      for (int i = 0; i < 32; i++) v[i] = p[i] & m_route[i][w-20];
    end
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_route[i] = 8'h00;
    m_en = 0; m_pol = 0; m_edge = 0; m_cond = 0; m_prev = 0; m_stick = 0;
    m_irq = 0; m_rhold = 0; rd_due = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      logic [31:0] p, mask, clrm, ns;
      logic [15:0] ni;
      int w;
      p = m_pend();
      ni = 0;
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 4; k++)
          for (int i = 0; i < 32; i++)
            if (p[i] && m_route[i][c] && m_route[i][4+k]) ni[c*4+k] = 1'b1;
      if (bus_rd) begin m_rhold = m_read(bus_addr); rd_due = 1; end
      for (int b = 0; b < 4; b++) mask[8*b +: 8] = {8{bus_be[b]}};
      w = bus_addr >> 2;
      clrm = (bus_wr && w == 16) ? (bus_wdata & mask) : 32'h0;
      for (int i = 0; i < 32; i++) begin
        if (!m_edge[i])                 ns[i] = 0;
        else if (m_cond[i] && !m_prev[i]) ns[i] = 1;
        else if (clrm[i])               ns[i] = 0;
        else                            ns[i] = m_stick[i];
      end
      m_stick = ns;
      m_prev  = m_cond;
      m_cond  = src_in ^ m_pol;
      if (bus_wr) begin
        if (w < 8) begin
          for (int b = 0; b < 4; b++) if (bus_be[b]) m_route[4*w+b] = bus_wdata[8*b +: 8];
        end
        else if (w == 10) m_en   = m_en | (bus_wdata & mask);
        else if (w == 11) m_en   = m_en & ~(bus_wdata & mask);
        else if (w == 12) m_pol  = (m_pol & ~mask) | (bus_wdata & mask);
        else if (w == 13) m_edge = (m_edge & ~mask) | (bus_wdata & mask);
      end
      m_irq = ni;
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (irq_out !== m_irq) begin
      fails++;
      $display("FAIL R8 R11 cycle %0d irq_out actual %h expected %h", cyc, irq_out, m_irq);
    end
    if (rd_due) begin
      rd_due = 0;
      vectors++;
      if (bus_rdata !== m_rhold) begin
        fails++;
        $display("FAIL %s addr %h rdata actual %h expected %h", cur_tag, bus_addr, bus_rdata, m_rhold);
      end
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = b;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_rd = 1; bus_addr = a; cur_tag = tag;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; src_in = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    // R1 reset state
    rd(8'h24, "R1"); rd(8'h30, "R1"); rd(8'h34, "R1"); rd(8'h40, "R1");
    rd(8'h00, "R1"); rd(8'h1C, "R1"); rd(8'h50, "R1");
    // R2 and R10 routing bytes with lane enables
    wr(8'h00, 32'hFFFFFF11, 4'b0001);
    wr(8'h04, 32'h00004200, 4'b0010);
    wr(8'h1E, 32'h88000000, 4'b1000);
    rd(8'h00, "R2 R10"); rd(8'h04, "R2"); rd(8'h1C, "R2");
    // R3 set and clear
    wr(8'h28, 32'h80000021, 4'hF); rd(8'h24, "R3"); rd(8'h28, "R3");
    wr(8'h2C, 32'h00000001, 4'hF); rd(8'h24, "R3"); rd(8'h2C, "R3");
    wr(8'h28, 32'h00000001, 4'hF); rd(8'h24, "R3");
    // R5 level-high on source 0 -> core0 line0
    src_in[0] = 1; idle(3); rd(8'h40, "R5 R7");
    wr(8'h40, 32'h00000001, 4'hF); idle(1); rd(8'h40, "R5");
    src_in[0] = 0; idle(3);
    // R4 level-low on source 5 -> core1 line2
    wr(8'h30, 32'h00000020, 4'hF); idle(3); rd(8'h30, "R4"); rd(8'h40, "R4");
    src_in[5] = 1; idle(3);
    // R6 rising edge on source 31 -> core3 line3
    wr(8'h34, 32'h80000000, 4'hF); rd(8'h34, "R4");
    src_in[31] = 1; idle(1); src_in[31] = 0; idle(3); rd(8'h40, "R6");
    wr(8'h40, 32'h80000000, 4'hF); idle(2); rd(8'h40, "R6");
    // R4 falling edge on source 0
    wr(8'h30, 32'h00000021, 4'hF); wr(8'h34, 32'h80000001, 4'hF); idle(2);
    wr(8'h40, 32'h00000001, 4'hF); idle(2); rd(8'h40, "R4");
    src_in[0] = 1; idle(3); src_in[0] = 0; idle(3); rd(8'h40, "R4 R6");
    wr(8'h40, 32'h00000001, 4'hF); idle(2);
    // R7 edge captured while disabled
    wr(8'h2C, 32'h80000000, 4'hF);
    src_in[31] = 1; idle(1); src_in[31] = 0; idle(3); rd(8'h40, "R7");
    wr(8'h28, 32'h80000000, 4'hF); idle(2); rd(8'h40, "R7");
    // R6 clear coincident with a new edge: edge wins
    wr(8'h40, 32'h80000000, 4'hF); idle(2);
    src_in[31] = 1; idle(1);
    wr(8'h40, 32'h80000000, 4'hF); src_in[31] = 0; idle(2); rd(8'h40, "R6");
    // R6 switching to level mode drops sticky bits
    wr(8'h34, 32'h00000000, 4'hF); idle(2); rd(8'h40, "R6");
    // R8 fan-out: source 3 to all sixteen outputs
    wr(8'h00, 32'hFF000000, 4'b1000); wr(8'h28, 32'h00000008, 4'hF);
    src_in[3] = 1; idle(3);
    // R9 per-core views
    rd(8'h50, "R9"); rd(8'h54, "R9"); rd(8'h58, "R9"); rd(8'h5C, "R9");
    // R10 no lanes enabled: clear has no effect
    wr(8'h2C, 32'hFFFFFFFF, 4'b0000); idle(2); rd(8'h24, "R10");
    wr(8'h2C, 32'h000000FF, 4'b0010); idle(2); rd(8'h24, "R10");
    // R11 read hold and byte-offset ignore
    rd(8'h27, "R10 R11"); idle(3);
    src_in[3] = 0; src_in[5] = 0; idle(4);
    finish_run();
  end
endmodule